// File: doc/BRIEF.md
# Two-Step Flash Conversion Sequencer

This block holds the digital control of a two-step (half-flash) analog-to-digital converter in which one bank of sixteen comparators serves both passes. In the coarse pass the bank compares the input against the coarse ladder, and its thermometer outputs are decoded into the upper result bits. The sequencer stores that code and only then enables the fine pass, in which the same bank resolves the residue into the four low bits. Once the fine pass has been decoded, the combined 10-bit word is latched and an active-low completion flag is pulled down.

There are two ways to start a conversion. In pin-timed mode the coarse pass lasts as long as the sample control is held asserted, and the pass ends when that control is released. In timer mode the sample and read pins are tied together. An internal timer of a fixed number of clock cycles then ends the coarse pass, whatever the pins do afterwards. Chip select qualifies both the sample and the read controls. The result bus is driven only during a qualified read and floats at all other times.

Top module: `two_step_flash_seq`

## Requirements
- R1: After reset, done_n is high, cmp_coarse and cmp_fine are low, and the stored result is zero.
- R2: A conversion starts only in the cycle in which the qualified sample (cs_n low and smp_n low) becomes true after a cycle in which it was false. Holding smp_n low while cs_n is high starts nothing.
- R3: In pin-timed mode (timed_mode low at start), cmp_coarse stays high for as many cycles as the qualified sample is held. The first cycle in which it is false captures the coarse code, and cmp_fine is high for exactly the following cycle.
- R4: In timer mode (timed_mode high at start), cmp_coarse stays high for exactly COARSE_CYC cycles, and then cmp_fine is high for one cycle.
- R5: Each pass decodes cmp_therm as the index of the highest asserted comparator plus one (0 when none is asserted). Asserted comparators below a gap (bubbles) do not change the code.
- R6: The fine code saturates at 15, so sixteen asserted comparators in the fine pass give 15.
- R7: The result latched at the end of the fine cycle is coarse_code*16 + fine_code. done_n falls on that same clock edge, and the result stays constant while done_n remains low.
- R8: done_n returns high on the clock edge that starts the next conversion.
- R9: dout carries the latched result only while cs_n and rd_n are both low. Otherwise it is high impedance.
- R10: Pin activity during a conversion neither restarts it nor changes the coarse length in timer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, qualifies sample and read |
| smp_n | input | 1 | Sample control, active low |
| rd_n | input | 1 | Read control, active low |
| timed_mode | input | 1 | 1: coarse pass ended by internal timer; 0: ended by sample release |
| cmp_therm | input | CMP_N (16) | Thermometer outputs of the shared comparator bank |
| cmp_coarse | output | 1 | Comparator bank working on the coarse pass |
| cmp_fine | output | 1 | Comparator bank working on the fine pass |
| done_n | output | 1 | Completion flag, active low |
| dout | output | RES_W (10) | Result bus, high impedance unless read is qualified |

## Verification
The embedded assertions check the ordering rules on every cycle: the fine enable only ever follows a coarse phase, and a fine cycle is always followed by idle. They also check that done_n falls only after a fine cycle, that a coarse phase starts only under a qualified sample with done_n released, that the timer-mode coarse span equals COARSE_CYC, and that the result holds still while done_n is low. The decoded values, including bubble codes and fine saturation, can only be shown by the bench scenarios. The same holds for high impedance on the bus and for the fact that gated or mid-conversion pin activity has no effect, since these show up only as data at the ports.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_COARSE = 2'd1,
      PH_FINE   = 2'd2
   } phase_t;
endpackage

// File: rtl/tsf_therm_dec.sv
module tsf_therm_dec #(
   parameter int N     = 16,
   parameter int OUT_W = 4
) (
   input  logic [N-1:0]     therm,
   output logic [OUT_W-1:0] code
);
   localparam int CNT_W   = $clog2(N + 1);
   localparam int MAX_VAL = (1 << OUT_W) - 1;

   if (N < 2) begin : g_bad_n
      $error("tsf_therm_dec: N must be at least 2");
   end
   if (OUT_W < 1) begin : g_bad_w
      $error("tsf_therm_dec: OUT_W must be at least 1");
   end

   logic [CNT_W-1:0] top_idx;

   // highest asserted comparator wins; bubbles below it are ignored (R5)
   always_comb begin
      top_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (therm[i]) top_idx = CNT_W'(i + 1);
      end
   end

   if (N <= MAX_VAL) begin : g_fit
      assign code = OUT_W'(top_idx);
   end else begin : g_sat
      // count range exceeds field: clamp (R6)
      assign code = (top_idx > CNT_W'(MAX_VAL)) ? OUT_W'(MAX_VAL)
                                                 : top_idx[OUT_W-1:0];
   end
endmodule

// File: rtl/tsf_seq.sv
module tsf_seq
   import tsf_pkg::*;
#(
   parameter int COARSE_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic samp,
   input  logic timed_mode,
   output logic start,
   output logic coarse_cap,
   output logic fine_done,
   output logic coarse_act,
   output logic fine_en
);
   localparam int TMR_W = (COARSE_CYC < 2) ? 1 : $clog2(COARSE_CYC);
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(COARSE_CYC - 1);

   if (COARSE_CYC < 1) begin : g_bad_cyc
      $error("tsf_seq: COARSE_CYC must be at least 1");
   end

   phase_t           ph;
   logic             samp_q;
   logic             mode_q;
   logic [TMR_W-1:0] tmr;

   assign start      = samp & ~samp_q & (ph == PH_IDLE);
   assign coarse_act = (ph == PH_COARSE);
   assign fine_en    = (ph == PH_FINE);
   assign fine_done  = fine_en;
   assign coarse_cap = coarse_act & (mode_q ? (tmr == TMR_LAST) : ~samp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         samp_q <= 1'b0;
         mode_q <= 1'b0;
         tmr    <= '0;
      end else begin
         samp_q <= samp;
         unique case (ph)
            PH_IDLE: if (start) begin
               ph     <= PH_COARSE;
               mode_q <= timed_mode;
               tmr    <= '0;
            end
            PH_COARSE: begin
               if (coarse_cap) ph <= PH_FINE;
               else if (mode_q) tmr <= tmr + 1'b1;
            end
            PH_FINE: ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // independent span counter for the timer-mode window check
   int unsigned span;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          span <= 0;
      else if (coarse_act) span <= span + 1;
      else                 span <= 0;
   end

   assert_timer_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fine_en) && mode_q) |-> (span == COARSE_CYC));

   assert_pin_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (coarse_act && !mode_q && !samp) |=> fine_en);

   assert_fine_after_coarse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fine_en) |-> $past(coarse_act));

   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fine_en |=> (!fine_en && !coarse_act));
endmodule

// File: rtl/two_step_flash_seq.sv
module two_step_flash_seq #(
   parameter int CMP_N      = 16,
   parameter int RES_W      = 10,
   parameter int FINE_W     = 4,
   parameter int COARSE_CYC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             smp_n,
   input  logic             rd_n,
   input  logic             timed_mode,
   input  logic [CMP_N-1:0] cmp_therm,
   output logic             cmp_coarse,
   output logic             cmp_fine,
   output logic             done_n,
   output logic [RES_W-1:0] dout
);
   localparam int COARSE_W = RES_W - FINE_W;

   if (FINE_W < 1 || FINE_W >= RES_W) begin : g_bad_split
      $error("two_step_flash_seq: FINE_W must be in 1..RES_W-1");
   end
   if ($clog2(CMP_N + 1) > COARSE_W) begin : g_bad_coarse
      $error("two_step_flash_seq: coarse field too narrow for CMP_N");
   end

   logic samp, rd_en;
   logic start, coarse_cap, fine_done;
   logic [COARSE_W-1:0] code_c, coarse_q;
   logic [FINE_W-1:0]   code_f;
   logic [RES_W-1:0]    result_q;
   logic                done_q;

   assign samp  = ~cs_n & ~smp_n;   // chip select gates sampling (R2)
   assign rd_en = ~cs_n & ~rd_n;    // chip select gates reading (R9)

   tsf_seq #(.COARSE_CYC(COARSE_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp       (samp),
      .timed_mode (timed_mode),
      .start      (start),
      .coarse_cap (coarse_cap),
      .fine_done  (fine_done),
      .coarse_act (cmp_coarse),
      .fine_en    (cmp_fine)
   );

   // same comparator bus, two views: wide coarse field, saturated fine field
   tsf_therm_dec #(.N(CMP_N), .OUT_W(COARSE_W)) u_dec_coarse (
      .therm (cmp_therm),
      .code  (code_c)
   );
   tsf_therm_dec #(.N(CMP_N), .OUT_W(FINE_W)) u_dec_fine (
      .therm (cmp_therm),
      .code  (code_f)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= '0;
         result_q <= '0;
         done_q   <= 1'b1;
      end else begin
         if (coarse_cap) coarse_q <= code_c;
         if (fine_done) begin
            result_q <= {coarse_q, code_f};
            done_q   <= 1'b0;
         end else if (start) begin
            done_q   <= 1'b1;
         end
      end
   end

   assign done_n = done_q;
   assign dout   = rd_en ? result_q : 'z;

   assert_done_after_fine_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_n) |-> $past(cmp_fine));

   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_n && $past(!done_n)) |-> $stable(result_q));

   assert_cs_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_coarse) |-> $past(!cs_n && !smp_n));

   assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_coarse) |-> done_n);

   assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_coarse && cmp_fine));
endmodule

// File: tb/two_step_flash_seq_bench.sv
module two_step_flash_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int COARSE_CYC = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, smp_n = 1'b1, rd_n = 1'b1, timed_mode = 1'b0;
   logic [15:0] cmp_therm = '0;
   logic        cmp_coarse, cmp_fine, done_n;
   wire  [9:0]  dout;

   two_step_flash_seq #(.COARSE_CYC(COARSE_CYC)) u_two_step_flash_seq (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .smp_n(smp_n), .rd_n(rd_n),
      .timed_mode(timed_mode), .cmp_therm(cmp_therm),
      .cmp_coarse(cmp_coarse), .cmp_fine(cmp_fine), .done_n(done_n),
      .dout(dout)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   bit summary_done = 0;
   int exp_q[$];
   int cyc_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
   endtask

   function automatic int top_code(input logic [15:0] t);
      int h = 0;
      for (int i = 0; i < 16; i++) if (t[i]) h = i + 1;
      return h;
   endfunction

   function automatic bit bus_off();
      return (dout === 10'bz) || (dout === 10'b0);
   endfunction

   // monitor: pops expected word and coarse length at each completion
   logic prev_done = 1'b1, prev_coarse = 1'b0;
   int   ccnt = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cmp_coarse && !prev_coarse)
            chk(done_n === 1'b1, "R8 done_n high at start", int'(done_n), 1);
         if (cmp_coarse) ccnt++;
         if (prev_done && !done_n) begin
            if (exp_q.size() == 0) begin
               chk(0, "R7 unexpected completion", int'(dout), -1);
            end else begin
               int e, c;
               e = exp_q.pop_front();
               c = cyc_q.pop_front();
               chk(dout === 10'(e), "R5/R6/R7 result", int'(dout), e);
               chk(ccnt == c, "R3/R4 coarse length", ccnt, c);
            end
            ccnt = 0;
         end
         prev_done   = done_n;
         prev_coarse = cmp_coarse;
      end
   end

   task automatic run_conv(input bit tmd, input logic [15:0] ct, input logic [15:0] ft,
                           input int hold, input bit glitch);
      int f;
      f = top_code(ft);
      if (f > 15) f = 15;
      exp_q.push_back(top_code(ct) * 16 + f);
      cyc_q.push_back(tmd ? COARSE_CYC : hold);
      @(negedge clk);
      timed_mode = tmd; cs_n = 0; cmp_therm = ct; smp_n = 0; rd_n = 0;
      if (tmd) begin
         if (glitch) begin   // R10: pin release mid-coarse must not shorten timer
            repeat (2) @(negedge clk);
            smp_n = 1; rd_n = 1;
            @(negedge clk);
            smp_n = 0; rd_n = 0;
         end
      end else begin
         repeat (hold) @(negedge clk);
         smp_n = 1;
      end
      do @(negedge clk); while (!cmp_fine);
      cmp_therm = ft;
      do @(negedge clk); while (done_n);
      @(negedge clk);
      smp_n = 1; rd_n = 1; cmp_therm = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(done_n === 1'b1, "R1 done_n", int'(done_n), 1);
      chk(!cmp_coarse && !cmp_fine, "R1 phases idle", int'({cmp_coarse, cmp_fine}), 0);
      cs_n = 0; rd_n = 0; #1;
      chk(dout === 10'd0, "R1 result zero", int'(dout), 0);
      @(negedge clk);
      // R2 sample with chip select high does nothing
      cs_n = 1; smp_n = 0; rd_n = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!cmp_coarse && done_n, "R2 gated sample", int'(cmp_coarse), 0);
      end
      #1 chk(bus_off(), "R9 bus off with cs_n high", int'(dout), 0);
      cs_n = 0; smp_n = 1; rd_n = 1;
      @(negedge clk);
      chk(!cmp_coarse, "R2 no late start", int'(cmp_coarse), 0);

      run_conv(0, 16'h00FF, 16'h0007, 3, 0);          // 8,3
      // R9 read gating on latched value 131
      cs_n = 0; rd_n = 1; #1;
      chk(bus_off(), "R9 rd_n high", int'(dout), 0);
      cs_n = 1; rd_n = 0; #1;
      chk(bus_off(), "R9 cs_n high", int'(dout), 0);
      cs_n = 0; rd_n = 0; #1;
      chk(dout === 10'd131, "R9 qualified read", int'(dout), 131);
      rd_n = 1;
      @(negedge clk);

      run_conv(1, 16'hFFFF, 16'hFFFF, 0, 0);          // 16, sat 15 (R6)
      run_conv(0, 16'h0000, 16'h0000, 1, 0);          // zero codes
      run_conv(0, 16'h043F, 16'h002B, 5, 0);          // bubbles (R5): 11,6
      run_conv(1, 16'h0001, 16'h7FFF, 0, 1);          // R10 glitch: 1,15
      run_conv(1, 16'h3FFF, 16'h8000, 0, 0);          // 14, bubble fine 16->15

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
      summary();
      $finish;
   end
endmodule